// File: doc/BRIEF.md
# CRC-32 Custom-Instruction Execution Unit

This unit sits next to a CPU pipeline and speeds up CRC-32 work through three custom instruction codes. The pipeline presents a command with a valid strobe, a 4-bit code and a 32-bit operand. Depending on the code, the unit loads its CRC state register from the operand, folds the operand into the state, or returns the state as the instruction result for write-back. A fold consumes a whole 32-bit word per instruction.

The fold uses the reflected CRC-32 with polynomial 0xEDB88320. The operand's bytes go in from the most significant to the least significant. Within each byte, bits go in least-significant first. Software picks the initial value by loading 0xFFFFFFFF or 0 before the first fold. The pipeline must not stall on this unit. `cmd_ready` is always high, so there is no back-pressure. Every command with valid high completes in the cycle it is presented, and `rsp_done` marks that cycle. A read result is taken from `rsp_data` in the same cycle.

Top module: `crc32_coproc`

## Requirements
- R1: While `rst_n` is low, the CRC state is set to 0xFFFFFFFF. A read issued as the first command after reset returns 0xFFFFFFFF.
- R2: A command with code 0x9 loads `cmd_operand` into the CRC state at the next clock edge.
- R3: A command with code 0x8 drives the current CRC state on `rsp_data` in the same cycle. In every other cycle, `rsp_data` is 0.
- R4: A command with code 0xA replaces the state in one cycle with the reflected CRC-32 update of four bytes. The polynomial is 0xEDB88320. The bytes are taken in the order operand[31:24], [23:16], [15:8], [7:0], and each byte's bits go in from bit 0 to bit 7.
- R5: A read in the cycle right after a fold or a load returns the updated state.
- R6: Start from a 0xFFFFFFFF seed and fold a frame's data words. Then fold the word made from the inverted CRC, with its bytes ordered low byte first in the word's top byte. The state then equals 0xDEBB20E3.
- R7: A valid command whose code is not 0x8, 0x9 or 0xA leaves the state unchanged. A cycle with `cmd_valid` low also leaves the state unchanged.
- R8: `cmd_ready` is always 1. `rsp_done` is 1 exactly in the cycles where `cmd_valid` is 1.
- R9: A read does not change the state, so two reads in a row return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe from the pipeline |
| cmd_ready | output | 1 | Always high; the unit never stalls the pipeline |
| cmd_code | input | 4 | Command code: 0x8 read, 0x9 load, 0xA fold |
| cmd_operand | input | 32 | Source operand |
| rsp_done | output | 1 | Completion pulse, same cycle as the command |
| rsp_data | output | 32 | Read result, 0 when not reading |

## Verification
The fold is checked against a bit-serial model in the bench, using several kinds of input. All-zero words from a zero seed must stay zero. Single-bit words tell a byte-order or bit-order mistake apart from a polynomial mistake. Random words from random seeds expose mixing errors between the byte stages. Frames that end in their own inverted CRC must land on the fixed residue, which shows that the byte order matches the frame convention. Unknown codes, idle gaps and repeated reads are mixed into the random stream. This shows that only the three defined codes touch the state.

// File: rtl/crc32_cp_pkg.sv
package crc32_cp_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] OP_READ  = 4'h8;
  localparam logic [CODE_W-1:0] OP_WRITE = 4'h9;
  localparam logic [CODE_W-1:0] OP_FOLD  = 4'hA;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
endpackage

// File: rtl/crc32_cp_decode.sv
module crc32_cp_decode
  import crc32_cp_pkg::*;
(
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic              fold_o
);
  always_comb begin
    rd_o   = 1'b0;
    wr_o   = 1'b0;
    fold_o = 1'b0;
    if (valid_i) begin
      unique case (code_i)
        OP_READ:  rd_o   = 1'b1;
        OP_WRITE: wr_o   = 1'b1;
        OP_FOLD:  fold_o = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/crc32_cp_byte.sv
module crc32_cp_byte #(
  parameter int          CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] step [0:8];
  assign step[0] = crc_i;
  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic fb;
    assign fb = step[b][0] ^ byte_i[b];
    assign step[b+1] = (step[b] >> 1) ^ (fb ? POLY : '0);
  end
  assign crc_o = step[8];
endmodule

// File: rtl/crc32_cp_fold.sv
module crc32_cp_fold #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int NBYTES = DATA_W / 8;
  logic [CRC_W-1:0] stage [0:NBYTES];
  assign stage[0] = crc_i;
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    crc32_cp_byte #(.CRC_W(CRC_W), .POLY(POLY)) u_byte (
      .crc_i  (stage[k]),
      .byte_i (word_i[DATA_W-1-8*k -: 8]),
      .crc_o  (stage[k+1])
    );
  end
  assign crc_o = stage[NBYTES];
endmodule

// File: rtl/crc32_coproc.sv
module crc32_coproc
  import crc32_cp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] cmd_operand,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data
);
  logic rd_en, wr_en, fold_en;
  logic [DATA_W-1:0] crc_q, crc_fold;

  crc32_cp_decode u_dec (
    .valid_i (cmd_valid),
    .code_i  (cmd_code),
    .rd_o    (rd_en),
    .wr_o    (wr_en),
    .fold_o  (fold_en)
  );

  crc32_cp_fold #(.CRC_W(DATA_W), .DATA_W(DATA_W), .POLY(CRC_POLY)) u_fold (
    .crc_i  (crc_q),
    .word_i (cmd_operand),
    .crc_o  (crc_fold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= CRC_SEED;
    else if (wr_en)   crc_q <= cmd_operand;
    else if (fold_en) crc_q <= crc_fold;
  end

  assign cmd_ready = 1'b1;
  assign rsp_done  = cmd_valid;
  assign rsp_data  = rd_en ? crc_q : '0;
endmodule

// File: rtl/crc32_coproc_chk.sv
module crc32_coproc_chk
  import crc32_cp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CODE_W-1:0] cmd_code,
  input logic [DATA_W-1:0] cmd_operand,
  input logic              rsp_done,
  input logic [DATA_W-1:0] rsp_data,
  input logic [DATA_W-1:0] crc_q
);
  AST_RESET_SEED: assert property (@(posedge clk) !rst_n |=> crc_q == 32'hFFFFFFFF); // R1
  AST_LOAD_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == OP_WRITE |=> crc_q == $past(cmd_operand)); // R2
  AST_READ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_WRITE) ##1 (cmd_valid && cmd_code == OP_READ)
      |-> rsp_data == $past(cmd_operand)); // R5
  AST_UNKNOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || (cmd_code != OP_READ && cmd_code != OP_WRITE && cmd_code != OP_FOLD))
      |=> $stable(crc_q)); // R7
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> rsp_done && cmd_ready); // R8
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == OP_READ |=> $stable(crc_q)); // R9
endmodule

bind crc32_coproc crc32_coproc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_code    (cmd_code),
  .cmd_operand (cmd_operand),
  .rsp_done    (rsp_done),
  .rsp_data    (rsp_data),
  .crc_q       (crc_q)
);

// File: tb/sim_crc32_coproc.sv
module sim_crc32_coproc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_code = 4'h0;
  logic [31:0] cmd_operand = '0;
  logic        rsp_done;
  logic [31:0] rsp_data;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] mdl;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc32_coproc u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_operand(cmd_operand), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] c, logic [31:0] w);
    c = ref_byte(c, w[31:24]);
    c = ref_byte(c, w[23:16]);
    c = ref_byte(c, w[15:8]);
    c = ref_byte(c, w[7:0]);
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] code, logic [31:0] op, output logic [31:0] rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_operand = op;
    #1;
    rd = rsp_data;
    check("R8 done", {30'd0, cmd_ready, rsp_done}, 32'd3);
    if (code != 4'h8) check("R3 idle data", rsp_data, 32'd0);
    if (code == 4'h9) mdl = op;
    else if (code == 4'hA) mdl = ref_word(mdl, op);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = $urandom % 16; cmd_operand = $urandom;
    #1;
    check("R8 no done", {31'd0, rsp_done}, 32'd0);
    check("R3 no read data", rsp_data, 32'd0);
    @(posedge clk);
  endtask

  task automatic rd_check(string req, logic [31:0] exp);
    logic [31:0] r;
    issue(4'h8, $urandom, r);
    check(req, r, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] r, c, fcs;
    void'($urandom(32'h5EED_C0DE));
    mdl = 32'hFFFFFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset seed
    rd_check("R1 reset value", 32'hFFFFFFFF);
    rd_check("R9 second read", 32'hFFFFFFFF);
    // R2 load zero, R4 zero word keeps zero
    issue(4'h9, 32'h0, r);
    rd_check("R2 load zero", 32'h0);
    issue(4'hA, 32'h0, r);
    rd_check("R4 zero fold", 32'h0);
    // R4 single-bit words, each byte lane
    for (int k = 0; k < 32; k += 7) begin
      issue(4'h9, 32'hFFFFFFFF, r);
      issue(4'hA, 32'h1 << k, r);
      rd_check("R4 single bit", ref_word(32'hFFFFFFFF, 32'h1 << k));
      rd_check("R5 read after fold", mdl);
    end
    // R7 unknown codes
    issue(4'h9, 32'h1234_5678, r);
    issue(4'h0, 32'hDEAD_BEEF, r);
    issue(4'h7, 32'hDEAD_BEEF, r);
    issue(4'hB, 32'hDEAD_BEEF, r);
    issue(4'hF, 32'hDEAD_BEEF, r);
    idle();
    rd_check("R7 unknown ignored", 32'h1234_5678);
    // R6 residue over frames
    for (int f = 0; f < 6; f++) begin
      issue(4'h9, 32'hFFFFFFFF, r);
      c = 32'hFFFFFFFF;
      for (int w = 0; w < 1 + f * 3; w++) begin
        logic [31:0] d;
        d = $urandom;
        c = ref_word(c, d);
        issue(4'hA, d, r);
      end
      fcs = ~c;
      issue(4'hA, {fcs[7:0], fcs[15:8], fcs[23:16], fcs[31:24]}, r);
      rd_check("R6 residue", 32'hDEBB20E3);
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom % 10;
      if (k < 4)      issue(4'hA, $urandom, r);
      else if (k < 5) issue(4'h9, $urandom, r);
      else if (k < 7) rd_check("R4 random fold", mdl);
      else if (k < 8) idle();
      else            issue(4'hB + ($urandom % 5), $urandom, r);
    end
    rd_check("R9 final read", mdl);
    idle();
    summary();
  end
endmodule